// File: doc/BRIEF.md
# Core-Local Timer and Software Interrupt Controller

This block gives every hart in a cluster two interrupt sources: a software interrupt that any bus master can raise or clear, and a timer interrupt that fires once a shared wall-clock counter catches up with a per-hart deadline. The number of harts is a parameter. The block holds one 64-bit counter shared by all harts. Each hart has a one-bit software pending flag and a 64-bit deadline (compare) register.

Software reaches the block over a simple 32-bit register bus with byte-lane write strobes. Each access completes with a ready pulse one cycle later. A 64-bit register is accessed as two 32-bit words. The counter advances on rising edges of a slow real-time clock input. That input is brought into the bus clock domain before it is used. Deadlines keep their value through reset, so a hart that is reset can find its previous deadline still in place.

Top module: `core_irq_timer`

## Requirements
- R1: `NUM_HARTS` sets the number of harts. Hart n owns bit n of `sw_irq` and bit n of `tmr_irq`, and each bit is driven independently of the others.
- R2: The software pending word of hart n is at byte offset 4·n. Only bit 0 can be written, and it drives `sw_irq[n]` from the clock edge that accepts the write. Bits 31:1 always read as zero. Outside an accepted bus write, `sw_irq` does not change.
- R3: Reset clears every software pending bit and the counter to zero.
- R4: The counter is 64 bits wide. It adds exactly one for each rising edge of `rtc_in`, with the carry passing from the low word into the high word. Without an edge or a write it holds its value.
- R5: `tmr_irq[n]` is a level, high exactly while counter ≥ deadline of hart n in an unsigned 64-bit compare. It follows a write to either operand on the next cycle.
- R6: The deadline of hart n has its low word at offset 0x4000 + 8·n and its high word at 0x4004 + 8·n. Both words can be read back. Deadlines are not reset and keep their contents across reset.
- R7: The counter low word is at offset 0xBFF8 and its high word is at 0xBFFC. Both words can be read and written.
- R8: On a write, strobe bit k updates only bits 8k+7:8k of the addressed word. A disabled lane keeps its old contents, and that includes bit 0 of a software pending word.
- R9: Reads from unmapped or non-word-aligned offsets return zero. Writes to them change no register.
- R10: `resp_ready` is high in the cycle after each cycle with `req_valid` high, and low otherwise. With it, `resp_rdata` carries the read data, or zero for a write.
- R11: A software write to either counter word in the same cycle as an increment takes priority, and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| rtc_in | input | 1 | Slow real-time clock, asynchronous to clk |
| req_valid | input | 1 | Access request, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| req_wstrb | input | 4 | Byte-lane write enables |
| resp_ready | output | 1 | Access complete, one cycle after request |
| resp_rdata | output | 32 | Read data, valid with resp_ready |
| sw_irq | output | NUM_HARTS | Software interrupt per hart |
| tmr_irq | output | NUM_HARTS | Timer interrupt level per hart |

## Verification
The timer-level property assumes that the counter never wraps from all ones to zero without a bus write. The stimulus keeps the counter far below that value. The counter step properties assume that `rtc_in` changes slowly compared with `clk`, so that each edge appears as one isolated tick. The bench holds every `rtc_in` level for several bus cycles. It keeps `rtc_in` still during reads, except in the one case that deliberately lines up a tick with a counter write. The deadline registers start undefined, so the bench writes all of them before it checks any timer level.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;

  // Byte offsets of the register regions
  localparam int unsigned SW_BASE  = 32'h0000_0000;
  localparam int unsigned CMP_BASE = 32'h0000_4000;
  localparam int unsigned TIME_LO  = 32'h0000_BFF8;
  localparam int unsigned TIME_HI  = 32'h0000_BFFC;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LANES   = WORD_W / 8;
  localparam int unsigned COUNT_W = 64;

  // Replace only the byte lanes whose strobe is set
  function automatic logic [WORD_W-1:0] lane_merge(
    input logic [WORD_W-1:0] old_w,
    input logic [WORD_W-1:0] new_w,
    input logic [LANES-1:0]  strb
  );
    logic [WORD_W-1:0] res;
    for (int b = 0; b < LANES; b++) begin
      res[8*b +: 8] = strb[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/irq_rtc_edge.sv
// Brings the slow real-time clock into the bus domain and emits a
// single-cycle tick on each rising edge.
module irq_rtc_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rtc_in,
  output logic tick
);

  localparam int unsigned SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[SH_W-2:0], rtc_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  // Synchronised level is sh_q[SH_W-2]; sh_q[SH_W-1] is its previous value
  assign tick = sh_q[SH_W-2] & ~sh_q[SH_W-1];

endmodule

// File: rtl/irq_wall_counter.sv
// Shared 64-bit wall-clock counter, software writable in two halves.
module irq_wall_counter
  import irq_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [WORD_W-1:0]  wdata,
  input  logic [LANES-1:0]   wstrb,
  output logic [COUNT_W-1:0] count
);

  logic [COUNT_W-1:0] cnt_q;
  logic [COUNT_W-1:0] cnt_d;
  logic               cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (wr_lo || wr_hi) begin
      // Software write wins over a coincident tick
      cnt_en = 1'b1;
      if (wr_lo) cnt_d[WORD_W-1:0]       = lane_merge(cnt_q[WORD_W-1:0], wdata, wstrb);
      if (wr_hi) cnt_d[COUNT_W-1:WORD_W] = lane_merge(cnt_q[COUNT_W-1:WORD_W], wdata, wstrb);
    end else if (tick) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + COUNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/irq_hart_slot.sv
// Per-hart state: software pending flag and a deadline without reset.
module irq_hart_slot
  import irq_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_we,
  input  logic               cmp_lo_we,
  input  logic               cmp_hi_we,
  input  logic [WORD_W-1:0]  wdata,
  input  logic [LANES-1:0]   wstrb,
  input  logic [COUNT_W-1:0] now,
  output logic               sw_pend,
  output logic [COUNT_W-1:0] deadline,
  output logic               tmr_lvl
);

  logic               sw_q;
  logic               sw_d;
  logic               sw_en;
  logic [COUNT_W-1:0] cmp_q;
  logic [COUNT_W-1:0] cmp_d;
  logic               cmp_en;

  always_comb begin
    sw_en = sw_we & wstrb[0];
    sw_d  = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= 1'b0;
    end else if (sw_en) begin
      sw_q <= sw_d;
    end
  end

  always_comb begin
    cmp_d  = cmp_q;
    cmp_en = cmp_lo_we | cmp_hi_we;
    if (cmp_lo_we) cmp_d[WORD_W-1:0]       = lane_merge(cmp_q[WORD_W-1:0], wdata, wstrb);
    if (cmp_hi_we) cmp_d[COUNT_W-1:WORD_W] = lane_merge(cmp_q[COUNT_W-1:WORD_W], wdata, wstrb);
  end

  // Deliberately no reset: contents survive a reset pulse
  always_ff @(posedge clk) begin
    if (cmp_en) begin
      cmp_q <= cmp_d;
    end
  end

  assign sw_pend  = sw_q;
  assign deadline = cmp_q;
  assign tmr_lvl  = (now >= cmp_q);

endmodule

// File: rtl/core_irq_timer.sv
module core_irq_timer
  import irq_timer_pkg::*;
#(
  parameter int unsigned NUM_HARTS   = 4,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rtc_in,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [WORD_W-1:0]    req_wdata,
  input  logic [LANES-1:0]     req_wstrb,
  output logic                 resp_ready,
  output logic [WORD_W-1:0]    resp_rdata,
  output logic [NUM_HARTS-1:0] sw_irq,
  output logic [NUM_HARTS-1:0] tmr_irq
);

  localparam int unsigned WA_W    = ADDR_W - 2;
  localparam int unsigned TLO_IDX = TIME_LO >> 2;
  localparam int unsigned THI_IDX = TIME_HI >> 2;

  logic [WA_W-1:0]      word_a;
  logic                 aligned;
  logic                 bus_wr;
  logic                 bus_rd;
  logic [NUM_HARTS-1:0] hit_sw;
  logic [NUM_HARTS-1:0] hit_clo;
  logic [NUM_HARTS-1:0] hit_chi;
  logic                 hit_tlo;
  logic                 hit_thi;
  logic                 addr_hit;
  logic                 time_wr;
  logic                 tick;
  logic [COUNT_W-1:0]   wall_time;
  logic [COUNT_W-1:0]   cmp_bank [NUM_HARTS];
  logic [NUM_HARTS-1:0] sw_vec;
  logic [NUM_HARTS-1:0] tmr_vec;
  logic [WORD_W-1:0]    rd_mux;

  assign word_a  = req_addr[ADDR_W-1:2];
  assign aligned = (req_addr[1:0] == 2'b00);
  assign bus_wr  = req_valid & req_write;
  assign bus_rd  = req_valid & ~req_write;
  assign hit_tlo = aligned && (word_a == WA_W'(TLO_IDX));
  assign hit_thi = aligned && (word_a == WA_W'(THI_IDX));
  assign time_wr = bus_wr & (hit_tlo | hit_thi);
  assign addr_hit = hit_tlo | hit_thi | (|hit_sw) | (|hit_clo) | (|hit_chi);

  irq_rtc_edge #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_rtc (
    .clk    (clk),
    .rst_n  (rst_n),
    .rtc_in (rtc_in),
    .tick   (tick)
  );

  irq_wall_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .wr_lo (bus_wr & hit_tlo),
    .wr_hi (bus_wr & hit_thi),
    .wdata (req_wdata),
    .wstrb (req_wstrb),
    .count (wall_time)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    localparam int unsigned SW_IDX = (SW_BASE >> 2) + h;
    localparam int unsigned CL_IDX = (CMP_BASE >> 2) + 2 * h;
    localparam int unsigned CH_IDX = CL_IDX + 1;

    assign hit_sw[h]  = aligned && (word_a == WA_W'(SW_IDX));
    assign hit_clo[h] = aligned && (word_a == WA_W'(CL_IDX));
    assign hit_chi[h] = aligned && (word_a == WA_W'(CH_IDX));

    irq_hart_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_we     (bus_wr & hit_sw[h]),
      .cmp_lo_we (bus_wr & hit_clo[h]),
      .cmp_hi_we (bus_wr & hit_chi[h]),
      .wdata     (req_wdata),
      .wstrb     (req_wstrb),
      .now       (wall_time),
      .sw_pend   (sw_vec[h]),
      .deadline  (cmp_bank[h]),
      .tmr_lvl   (tmr_vec[h])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int h = 0; h < NUM_HARTS; h++) begin
      if (hit_sw[h])  rd_mux = {{(WORD_W-1){1'b0}}, sw_vec[h]};
      if (hit_clo[h]) rd_mux = cmp_bank[h][WORD_W-1:0];
      if (hit_chi[h]) rd_mux = cmp_bank[h][COUNT_W-1:WORD_W];
    end
    if (hit_tlo) rd_mux = wall_time[WORD_W-1:0];
    if (hit_thi) rd_mux = wall_time[COUNT_W-1:WORD_W];
  end

  // Response stage: one-cycle ready, registered read data
  logic              rdy_q;
  logic              rdy_d;
  logic [WORD_W-1:0] rdata_q;
  logic [WORD_W-1:0] rdata_d;
  logic              rdata_en;

  always_comb begin
    rdy_d    = req_valid;
    rdata_en = req_valid | rdy_q;
    rdata_d  = bus_rd ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rdy_q <= rdy_d;
      if (rdata_en) rdata_q <= rdata_d;
    end
  end

  assign resp_ready = rdy_q;
  assign resp_rdata = rdata_q;
  assign sw_irq     = sw_vec;
  assign tmr_irq    = tmr_vec;

endmodule

// File: rtl/core_irq_timer_chk.sv
module core_irq_timer_chk #(
  parameter int unsigned NUM_HARTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_write,
  input logic                 addr_hit,
  input logic                 bus_wr,
  input logic                 tick,
  input logic                 time_wr,
  input logic [63:0]          wall_time,
  input logic                 resp_ready,
  input logic [31:0]          resp_rdata,
  input logic [NUM_HARTS-1:0] sw_irq,
  input logic [NUM_HARTS-1:0] tmr_irq
);

  // R3: while reset is held, pending flags and counter are zero
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R3: assert (sw_irq == '0 && wall_time == 64'd0);
    end
  end

  assert_ready_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_ready);

  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_ready);

  assert_tick_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !time_wr) |=> (wall_time == $past(wall_time) + 64'd1));

  assert_time_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !time_wr) |=> $stable(wall_time));

  assert_sw_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(sw_irq));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !addr_hit) |=> (resp_rdata == 32'd0));

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_lvl
    assert_tmr_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_irq[h] && !bus_wr && (wall_time != '1)) |=> tmr_irq[h]);
  end

endmodule

bind core_irq_timer core_irq_timer_chk #(
  .NUM_HARTS (NUM_HARTS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .addr_hit   (addr_hit),
  .bus_wr     (bus_wr),
  .tick       (tick),
  .time_wr    (time_wr),
  .wall_time  (wall_time),
  .resp_ready (resp_ready),
  .resp_rdata (resp_rdata),
  .sw_irq     (sw_irq),
  .tmr_irq    (tmr_irq)
);

// File: tb/core_irq_timer_tb.sv
`timescale 1ns/1ps
module core_irq_timer_tb;

  localparam int unsigned N = 4;
  localparam logic [15:0] A_TLO = 16'hBFF8;
  localparam logic [15:0] A_THI = 16'hBFFC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          rtc_in = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [15:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [3:0]    req_wstrb = '0;
  logic          resp_ready;
  logic [31:0]   resp_rdata;
  logic [N-1:0]  sw_irq;
  logic [N-1:0]  tmr_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] exp_cmp [N];

  always #2 clk = ~clk;

  core_irq_timer #(.NUM_HARTS(N), .ADDR_W(16)) u_dut (
    .clk, .rst_n, .rtc_in, .req_valid, .req_write, .req_addr,
    .req_wdata, .req_wstrb, .resp_ready, .resp_rdata, .sw_irq, .tmr_irq
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_wstrb = s;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wstrb = '0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = resp_rdata;
  endtask

  task automatic rd64(input logic [15:0] a, output logic [63:0] v);
    logic [31:0] lo, hi;
    bus_read(a, lo);
    bus_read(a + 16'd4, hi);
    v = {hi, lo};
  endtask

  task automatic wr_cmp(input int h, input logic [63:0] v);
    bus_write(16'h4000 + 16'(8*h), v[31:0], 4'hF);
    bus_write(16'h4004 + 16'(8*h), v[63:32], 4'hF);
    exp_cmp[h] = v;
  endtask

  task automatic wr_time(input logic [63:0] v);
    bus_write(A_THI, v[63:32], 4'hF);
    bus_write(A_TLO, v[31:0], 4'hF);
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    logic [63:0] v;
    chk("R3", "sw_irq after reset", 64'(sw_irq), 64'd0);
    chk("R10", "ready idle after reset", 64'(resp_ready), 64'd0);
    rd64(A_TLO, v);
    chk("R3", "counter after reset", v, 64'd0);
  endtask

  task automatic t_ready_timing();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = A_TLO;
    chk("R10", "ready in request cycle", 64'(resp_ready), 64'd0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "ready one cycle later", 64'(resp_ready), 64'd1);
    chk("R10", "read data with ready", 64'(resp_rdata), 64'd0);
    @(negedge clk);
    chk("R10", "ready drops", 64'(resp_ready), 64'd0);
  endtask

  task automatic t_cmp_init();
    logic [63:0] v;
    for (int h = 0; h < N; h++) wr_cmp(h, 64'h0000_0010_0000_0000 + 64'(h));
    for (int h = 0; h < N; h++) begin
      rd64(16'h4000 + 16'(8*h), v);
      chk("R6", "deadline read-back", v, exp_cmp[h]);
    end
    chk("R5", "no timer irq with counter below deadlines", 64'(tmr_irq), 64'd0);
  endtask

  task automatic t_sw_pend();
    logic [31:0] d;
    bus_write(16'h0008, 32'hFFFF_FFFF, 4'hF);
    chk("R1", "only hart 2 software line", 64'(sw_irq), 64'b0100);
    bus_read(16'h0008, d);
    chk("R2", "upper bits read zero", 64'(d), 64'd1);
    bus_write(16'h0000, 32'h1, 4'hF);
    chk("R2", "hart 0 raised", 64'(sw_irq), 64'b0101);
    bus_write(16'h0008, 32'h0, 4'b1110);
    chk("R8", "bit 0 lane disabled keeps flag", 64'(sw_irq), 64'b0101);
    bus_write(16'h0008, 32'h0, 4'b0001);
    chk("R2", "hart 2 cleared", 64'(sw_irq), 64'b0001);
    bus_write(16'h0000, 32'h0, 4'hF);
    chk("R2", "all cleared", 64'(sw_irq), 64'b0000);
  endtask

  task automatic t_strobe();
    logic [31:0] d;
    bus_write(16'h4008, 32'hAABB_CCDD, 4'b0101);
    bus_read(16'h4008, d);
    chk("R8", "lanes 0 and 2", 64'(d), 64'h00BB_00DD);
    bus_write(16'h4008, 32'h1122_3344, 4'b1010);
    bus_read(16'h4008, d);
    chk("R8", "lanes 1 and 3", 64'(d), 64'h11BB_33DD);
    exp_cmp[1][31:0] = 32'h11BB_33DD;
  endtask

  task automatic t_time_rw();
    logic [63:0] v;
    wr_time(64'h0123_4567_89AB_CDEF);
    rd64(A_TLO, v);
    chk("R7", "counter write/read", v, 64'h0123_4567_89AB_CDEF);
    bus_write(A_THI, 32'hFFFF_0000, 4'b0011);
    rd64(A_TLO, v);
    chk("R8", "half-word counter write", v, 64'h0123_0000_89AB_CDEF);
  endtask

  task automatic t_tick_count();
    logic [63:0] v;
    wr_time(64'h0000_0000_FFFF_FFFE);
    for (int p = 0; p < 5; p++) begin
      @(negedge clk); rtc_in = 1'b1;
      repeat (4) @(negedge clk);
      rtc_in = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    rd64(A_TLO, v);
    chk("R4", "five edges with carry", v, 64'h0000_0001_0000_0003);
  endtask

  task automatic t_irq_levels();
    wr_cmp(0, 64'h0000_0001_0000_0003);
    wr_cmp(1, 64'h0000_0001_0000_0004);
    wr_cmp(2, 64'h0000_0000_FFFF_FFFF);
    wr_cmp(3, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R5", "equal, above, high-word below, max", 64'(tmr_irq), 64'b0101);
    bus_write(A_THI, 32'h8000_0000, 4'hF);
    chk("R5", "unsigned compare with bit 63 set", 64'(tmr_irq), 64'b0111);
    wr_cmp(1, 64'hFFFF_FFFF_0000_0004);
    chk("R5", "raised deadline clears level", 64'(tmr_irq), 64'b0101);
    repeat (5) @(negedge clk);
    chk("R5", "level persists", 64'(tmr_irq), 64'b0101);
  endtask

  task automatic t_write_priority();
    logic [63:0] v;
    wr_time(64'h0000_0000_0000_0100);
    @(negedge clk); rtc_in = 1'b1;
    @(negedge clk);
    bus_write(A_TLO, 32'h0000_0500, 4'hF);
    rtc_in = 1'b0;
    repeat (6) @(negedge clk);
    rd64(A_TLO, v);
    chk("R11", "write beats coincident tick", v, 64'h0000_0000_0000_0500);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    logic [63:0] v;
    logic [N-1:0] tmr_before;
    bus_write(16'h0004, 32'h1, 4'hF);
    tmr_before = tmr_irq;
    bus_write(16'h0010, 32'h1, 4'hF);
    bus_write(16'h4020, 32'h0, 4'hF);
    bus_write(16'h8000, 32'h0, 4'hF);
    bus_write(16'hBFF9, 32'h0, 4'hF);
    chk("R9", "sw lines untouched", 64'(sw_irq), 64'b0010);
    chk("R9", "timer lines untouched", 64'(tmr_irq), 64'(tmr_before));
    bus_read(16'h0010, d);
    chk("R9", "read past sw region", 64'(d), 64'd0);
    bus_read(16'h4020, d);
    chk("R9", "read past deadline bank", 64'(d), 64'd0);
    bus_read(16'hBFF9, d);
    chk("R9", "misaligned read", 64'(d), 64'd0);
    rd64(A_TLO, v);
    chk("R9", "counter untouched", v, 64'h0000_0000_0000_0500);
    rd64(16'h4000, v);
    chk("R9", "deadline 0 untouched", v, exp_cmp[0]);
  endtask

  task automatic t_cmp_keep();
    logic [63:0] v;
    pulse_reset();
    chk("R3", "sw cleared by reset", 64'(sw_irq), 64'd0);
    rd64(A_TLO, v);
    chk("R3", "counter cleared by reset", v, 64'd0);
    for (int h = 0; h < N; h++) begin
      rd64(16'h4000 + 16'(8*h), v);
      chk("R6", "deadline kept through reset", v, exp_cmp[h]);
    end
    chk("R5", "no level with counter zero", 64'(tmr_irq), 64'd0);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_ready_timing();
    t_cmp_init();
    t_sw_pend();
    t_strobe();
    t_time_rw();
    t_tick_count();
    t_irq_levels();
    t_write_priority();
    t_unmapped();
    t_cmp_keep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule